// File: doc/BRIEF.md
# SIMD Modified Immediate Expander

This block turns a compact vector immediate into a full 64-bit constant. It takes an 8-bit immediate and a 5-bit format selector. The selector is built from a one-bit operation flag above a four-bit mode code. The block decodes the selector and applies one of five forms:

- replicate the byte into every byte lane;
- spread each immediate bit across a whole byte;
- place the byte in a halfword and shift it left;
- place the byte in a word and shift it left;
- place the byte in a word, shift it left and fill the vacated low bits with ones.

With the constant the block reports the element size, the shift amount and a flag for the ones-fill form. Selector values that match no form are flagged as bad.

A caller raises the valid strobe with an immediate and a selector. One clock later the registered result appears with its own valid. Between requests the last result stays on the outputs. Applying the constant to vector lanes is left to the consumer.

Top module: `simdImmExpand`

## Requirements
- R1: Selector 0x0E copies the immediate into all eight byte lanes; element size 8, shift 0, ones flag 0, bad flag 0.
- R2: Selector 0x1E expands immediate bit i into byte lane i (bits 8i+7..8i), giving 0xFF for a set bit and 0x00 for a clear bit; element size 64, shift 0.
- R3: When selector bits 3:2 equal 2'b10, the immediate sits in a 16-bit lane shifted left by 8 times selector bit 1, and that lane is repeated four times; element size 16, shift reported as 0 or 8.
- R4: When selector bit 3 is 0, the immediate sits in a 32-bit lane shifted left by 8 times selector bits 2:1 (0, 8, 16 or 24), and that lane is repeated twice; element size 32.
- R5: When selector bits 3:1 equal 3'b110, the immediate sits in a 32-bit lane shifted left by 8 (selector bit 0 clear) or by 16 (bit 0 set). All bits below the immediate are ones and the lane is repeated twice. Element size 32, ones flag 1, shift reported as 8 or 16.
- R6: Selectors 0x0F and 0x1F raise the bad flag and drive the value, element size, shift and ones flag to zero.
- R7: Output valid rises in the cycle after an accepted request and is low in the cycle after a cycle without one. All result outputs hold their values while no request arrives.
- R8: After reset, output valid, value, element size, shift, ones flag and bad flag are all zero.
- R9: The selector's top bit has no effect on the result except in telling 0x0E from 0x1E and 0x0F from 0x1F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Request strobe |
| imm | input | 8 | Immediate byte |
| opCmode | input | 5 | Format selector: operation flag in bit 4, mode code in bits 3:0 |
| outValid | output | 1 | Result valid, one cycle after the request |
| outValue | output | 64 | Expanded constant |
| elemBits | output | 7 | Element size in bits (8, 16, 32, 64, or 0 when bad) |
| shiftAmt | output | 5 | Left shift applied to the immediate, in bits |
| onesIn | output | 1 | Vacated low bits were filled with ones |
| badCode | output | 1 | Selector matched no form |

## Verification
The assertions assume that a request is a single-cycle strobe sampled at the rising edge. They also assume that the selector and immediate are settled when the strobe is high. The bench drives every input at the falling edge, so these assumptions hold. The stimulus covers all 32 selector values against several immediate patterns, both back-to-back and with idle gaps. A final quiet phase changes the data inputs with the strobe low, which exercises the hold rule.

// File: rtl/simdImmPkg.sv
package simdImmPkg;
  localparam int IMM_W   = 8;
  localparam int OC_W    = 5;
  localparam int VAL_W   = 64;
  localparam int HALF_W  = 2 * IMM_W;
  localparam int WORD_W  = 4 * IMM_W;
  localparam int ELEM_W  = $clog2(VAL_W) + 1;
  localparam int SHIFT_W = $clog2(WORD_W);
  localparam int SEL_W   = 2;

  typedef enum logic [2:0] {
    FORM_NONE,
    FORM_BYTE,
    FORM_BITS,
    FORM_HALF,
    FORM_WORD,
    FORM_ONES
  } form_e;

  // strobes from control to datapath
  typedef struct packed {
    logic             load;
    form_e            form;
    logic [SEL_W-1:0] shiftSel;
  } ctrl_t;
endpackage

// File: rtl/simdImmCtrl.sv
module simdImmCtrl
  import simdImmPkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  logic [OC_W-1:0] opCmode,
  output ctrl_t           ctrl,
  output logic            outValid
);
  logic [3:0] mode;
  assign mode = opCmode[3:0];

  always_comb begin
    ctrl.load     = inValid;
    ctrl.form     = FORM_NONE;
    ctrl.shiftSel = '0;
    if (opCmode == OC_W'(5'h0E)) begin
      ctrl.form = FORM_BYTE;
    end else if (opCmode == OC_W'(5'h1E)) begin
      ctrl.form = FORM_BITS;
    end else if (mode[3:2] == 2'b10) begin
      ctrl.form     = FORM_HALF;
      ctrl.shiftSel = {1'b0, mode[1]};
    end else if (!mode[3]) begin
      ctrl.form     = FORM_WORD;
      ctrl.shiftSel = mode[2:1];
    end else if (mode[3:1] == 3'b110) begin
      ctrl.form     = FORM_ONES;
      ctrl.shiftSel = {1'b0, mode[0]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN) inValid |=> outValid); // R7
  AST_VALID_QUIET: assert property (@(posedge clk) disable iff (!rstN) !inValid |=> !outValid); // R7
  AST_HALF_SEL: assert property (@(posedge clk) disable iff (!rstN) (inValid && ctrl.form == FORM_HALF) |-> !ctrl.shiftSel[1]); // R3
  AST_TOP_CODES: assert property (@(posedge clk) disable iff (!rstN) (inValid && opCmode[3:0] == 4'hF) |-> ctrl.form == FORM_NONE); // R6
endmodule

// File: rtl/simdImmData.sv
module simdImmData
  import simdImmPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctrl_t              ctrl,
  input  logic [IMM_W-1:0]   imm,
  output logic [VAL_W-1:0]   outValue,
  output logic [ELEM_W-1:0]  elemBits,
  output logic [SHIFT_W-1:0] shiftAmt,
  output logic               onesIn,
  output logic               badCode
);
  localparam int LANES  = VAL_W / IMM_W;
  localparam int HALVES = VAL_W / HALF_W;
  localparam int WORDS  = VAL_W / WORD_W;

  logic [SHIFT_W-1:0] plainShift, onesShift;
  logic [HALF_W-1:0]  halfLane;
  logic [WORD_W-1:0]  wordLane, onesFill, onesLane;
  logic [VAL_W-1:0]   repByte, bitBytes, repHalf, repWord, repOnes;

  assign plainShift = SHIFT_W'(ctrl.shiftSel) * SHIFT_W'(IMM_W);
  assign onesShift  = plainShift + SHIFT_W'(IMM_W);
  assign halfLane   = HALF_W'(imm) << plainShift;
  assign wordLane   = WORD_W'(imm) << plainShift;
  assign onesFill   = (WORD_W'(1) << onesShift) - WORD_W'(1);
  assign onesLane   = (WORD_W'(imm) << onesShift) | onesFill;

  for (genvar g = 0; g < LANES; g++) begin : gByte
    assign repByte[g*IMM_W +: IMM_W] = imm;
    if (g < IMM_W) begin : gBit
      assign bitBytes[g*IMM_W +: IMM_W] = {IMM_W{imm[g]}};
    end else begin : gPad
      assign bitBytes[g*IMM_W +: IMM_W] = '0;
    end
  end
  for (genvar g = 0; g < HALVES; g++) begin : gHalf
    assign repHalf[g*HALF_W +: HALF_W] = halfLane;
  end
  for (genvar g = 0; g < WORDS; g++) begin : gWord
    assign repWord[g*WORD_W +: WORD_W] = wordLane;
    assign repOnes[g*WORD_W +: WORD_W] = onesLane;
  end

  logic [VAL_W-1:0]   nextValue;
  logic [ELEM_W-1:0]  nextElem;
  logic [SHIFT_W-1:0] nextShift;
  logic               nextOnes, nextBad;

  always_comb begin
    nextValue = '0;
    nextElem  = '0;
    nextShift = '0;
    nextOnes  = 1'b0;
    nextBad   = 1'b0;
    case (ctrl.form)
      FORM_BYTE: begin
        nextValue = repByte;
        nextElem  = ELEM_W'(IMM_W);
      end
      FORM_BITS: begin
        nextValue = bitBytes;
        nextElem  = ELEM_W'(VAL_W);
      end
      FORM_HALF: begin
        nextValue = repHalf;
        nextElem  = ELEM_W'(HALF_W);
        nextShift = plainShift;
      end
      FORM_WORD: begin
        nextValue = repWord;
        nextElem  = ELEM_W'(WORD_W);
        nextShift = plainShift;
      end
      FORM_ONES: begin
        nextValue = repOnes;
        nextElem  = ELEM_W'(WORD_W);
        nextShift = onesShift;
        nextOnes  = 1'b1;
      end
      default: nextBad = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValue <= '0;
      elemBits <= '0;
      shiftAmt <= '0;
      onesIn   <= 1'b0;
      badCode  <= 1'b0;
    end else if (ctrl.load) begin
      outValue <= nextValue;
      elemBits <= nextElem;
      shiftAmt <= nextShift;
      onesIn   <= nextOnes;
      badCode  <= nextBad;
    end
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN) !ctrl.load |=> ($stable(outValue) && $stable(elemBits) && $stable(badCode))); // R7
  AST_BITS_FILL: assert property (@(posedge clk) disable iff (!rstN) (ctrl.load && ctrl.form == FORM_BITS) |=> (elemBits == ELEM_W'(VAL_W) && shiftAmt == '0)); // R2
endmodule

// File: rtl/simdImmExpand.sv
module simdImmExpand
  import simdImmPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [IMM_W-1:0]   imm,
  input  logic [OC_W-1:0]    opCmode,
  output logic               outValid,
  output logic [VAL_W-1:0]   outValue,
  output logic [ELEM_W-1:0]  elemBits,
  output logic [SHIFT_W-1:0] shiftAmt,
  output logic               onesIn,
  output logic               badCode
);
  ctrl_t ctrl;

  simdImmCtrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .opCmode  (opCmode),
    .ctrl     (ctrl),
    .outValid (outValid)
  );

  simdImmData uData (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .imm      (imm),
    .outValue (outValue),
    .elemBits (elemBits),
    .shiftAmt (shiftAmt),
    .onesIn   (onesIn),
    .badCode  (badCode)
  );

  AST_BAD_ZERO: assert property (@(posedge clk) disable iff (!rstN) (outValid && badCode) |-> (outValue == '0 && elemBits == '0 && !onesIn)); // R6
  AST_ONES_LOW: assert property (@(posedge clk) disable iff (!rstN) (outValid && onesIn) |-> (outValue[IMM_W-1:0] == '1 && elemBits == ELEM_W'(WORD_W))); // R5
  AST_ELEM_LEGAL: assert property (@(posedge clk) disable iff (!rstN) (outValid && !badCode) |-> $countones(elemBits) == 1); // R1
endmodule

// File: tb/simdImmExpand_test.sv
module simdImmExpand_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [7:0]  imm = '0;
  logic [4:0]  opCmode = '0;
  logic        outValid;
  logic [63:0] outValue;
  logic [6:0]  elemBits;
  logic [4:0]  shiftAmt;
  logic        onesIn;
  logic        badCode;

  int total = 0;
  int bad = 0;
  bit done = 0;

  typedef struct {
    logic [63:0] v;
    int          e;
    int          s;
    bit          o;
    bit          b;
    string       req;
  } exp_t;

  exp_t q[$];
  exp_t lastExp;

  always #(CLK_PERIOD/2) clk = ~clk;

  simdImmExpand uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .imm(imm), .opCmode(opCmode),
    .outValid(outValid), .outValue(outValue), .elemBits(elemBits),
    .shiftAmt(shiftAmt), .onesIn(onesIn), .badCode(badCode)
  );

  function automatic exp_t model(logic [7:0] x, logic [4:0] sel);
    exp_t r;
    logic [31:0] w;
    logic [15:0] h;
    int sh;
    r.v = '0; r.e = 0; r.s = 0; r.o = 0; r.b = 0;
    if (sel == 5'h0E) begin
      for (int i = 0; i < 8; i++) r.v[8*i +: 8] = x;
      r.e = 8; r.req = "R1";
    end else if (sel == 5'h1E) begin
      for (int i = 0; i < 8; i++) r.v[8*i +: 8] = x[i] ? 8'hFF : 8'h00;
      r.e = 64; r.req = "R2";
    end else if (sel[3:2] == 2'b10) begin
      sh = sel[1] ? 8 : 0;
      h = {8'h00, x} << sh;
      r.v = {h, h, h, h}; r.e = 16; r.s = sh; r.req = "R3";
    end else if (sel[3] == 1'b0) begin
      sh = 8 * int'(sel[2:1]);
      w = {24'h0, x} << sh;
      r.v = {w, w}; r.e = 32; r.s = sh; r.req = "R4";
    end else if (sel[3:1] == 3'b110) begin
      sh = sel[0] ? 16 : 8;
      w = ({24'h0, x} << sh) | ((32'h1 << sh) - 32'h1);
      r.v = {w, w}; r.e = 32; r.s = sh; r.o = 1; r.req = "R5";
    end else begin
      r.b = 1; r.req = "R6";
    end
    if (sel[4] && sel != 5'h1E && sel != 5'h1F) r.req = {r.req, "/R9"};
    return r;
  endfunction

  task automatic send(logic [7:0] x, logic [4:0] sel);
    @(negedge clk);
    inValid = 1'b1; imm = x; opCmode = sel;
    q.push_back(model(x, sel));
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0; imm = imm ^ 8'h5A; opCmode = opCmode + 5'd3;
    end
  endtask

  // monitor: pop and compare
  always @(negedge clk) begin
    if (rstN && outValid && !done) begin
      exp_t e;
      total++;
      if (q.size() == 0) begin
        bad++;
        $display("FAIL R7: unexpected result, actual outValid=1 expected 0");
      end else begin
        e = q.pop_front();
        lastExp = e;
        if (outValue !== e.v || int'(elemBits) != e.e || int'(shiftAmt) != e.s ||
            onesIn !== e.o || badCode !== e.b) begin
          bad++;
          $display("FAIL %s: actual v=%h e=%0d s=%0d o=%0b b=%0b expected v=%h e=%0d s=%0d o=%0b b=%0b",
                   e.req, outValue, elemBits, shiftAmt, onesIn, badCode, e.v, e.e, e.s, e.o, e.b);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] pats [6];
    logic [7:0] lfsr;
    pats = '{8'h00, 8'hFF, 8'hA5, 8'h81, 8'h3C, 8'h01};
    repeat (3) @(negedge clk);
    // R8: reset state
    total++;
    if (outValid !== 0 || outValue !== '0 || elemBits !== '0 || shiftAmt !== '0 ||
        onesIn !== 0 || badCode !== 0) begin
      bad++;
      $display("FAIL R8: actual v=%h e=%0d s=%0d valid=%0b expected all zero",
               outValue, elemBits, shiftAmt, outValid);
    end
    rstN = 1'b1;
    // all selectors, back to back
    for (int p = 0; p < 6; p++)
      for (int c = 0; c < 32; c++) send(pats[p], 5'(c));
    idle(2);
    // pseudo-random with gaps
    lfsr = 8'h2D;
    for (int i = 0; i < 200; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      send(lfsr, 5'(lfsr ^ 8'(i)));
      if (i % 7 == 3) idle(1 + i % 3);
    end
    idle(3);
    total++;
    if (q.size() != 0) begin
      bad++;
      $display("FAIL R7: actual pending=%0d expected 0", q.size());
    end
    // R7: hold while idle with changing inputs
    for (int i = 0; i < 4; i++) begin
      idle(1);
      @(negedge clk);
      total++;
      if (outValid !== 0 || outValue !== lastExp.v || int'(elemBits) != lastExp.e ||
          badCode !== lastExp.b) begin
        bad++;
        $display("FAIL R7: actual valid=%0b v=%h expected valid=0 v=%h",
                 outValid, outValue, lastExp.v);
      end
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule